// File: doc/BRIEF.md
# SD Command Line Host Engine

This block drives the host side of a single-bit SD command line. On a start request it builds a 48-bit command frame from a 6-bit command index and a 32-bit argument. The frame is a start bit, a host direction flag, the index, the argument, a 7-bit CRC and an end bit. The block shifts the frame out one bit per clock, most significant bit first. The caller must already have divided the clock down to the bit rate; the pad driver sits outside this block.

After the last command bit, the block acts on the response kind latched with the command. It can finish at once. It can instead listen for a short 48-bit reply, with or without a CRC check, or for a long 136-bit reply. When a reply arrives, the block collects it, checks the direction flag and the end bit, and checks the CRC where the kind calls for one. It then reports the payload together with error flags. If no start bit appears within a bounded window, the command ends with a timeout. Each command ends with a one-cycle `done` pulse. The result flags and data stay valid until the next command is accepted.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset `busy`, `done`, `cmd_oe`, `timeout`, `crc_err` and `frame_err` are 0, `cmd_out` is 1 and `rsp_data` is 0.
- R2: A `start` seen with `busy` low is accepted at that clock edge. For the next 48 cycles `cmd_oe` is 1 and `cmd_out` carries, MSB first: 0, 1, the index (6 bits), the argument (32 bits), the CRC7, then 1.
- R3: The CRC7 uses x^7+x^3+1, a zero start value, and covers the first 40 frame bits; index 0 with argument 0 gives 7'h4A, and index 8 with argument 32'h1AA gives 7'h43.
- R4: `rsp_kind` encoding: 0 = no reply, 1 = short reply with CRC check, 2 = short reply without CRC check, 3 = long reply. With kind 0, `done` pulses and `busy` falls at the edge after the last command bit, with all flags 0.
- R5: `start` while `busy` is high is ignored; no second frame follows.
- R6: After the frame, the line is sampled on 64 edges. If none of those edges sees 0, `done` and `timeout` are set on the 64th edge. A start bit on the 64th edge is still accepted.
- R7: A short reply is 48 bits: 0, direction, 38 content bits, CRC7, 1. `rsp_data[37:0]` holds the 38 content bits and the bits above them are 0.
- R8: A long reply is 136 bits: 0, direction, 6 reserved bits, 120 payload bits, CRC7, 1. `rsp_data` holds the reserved and payload bits (126 bits), and the CRC covers only the 120 payload bits.
- R9: A CRC mismatch sets `crc_err` for kinds 1 and 3. Kind 2 never sets `crc_err`.
- R10: A received direction bit of 1, or an end bit of 0, sets `frame_err`.
- R11: `done` is high for exactly one cycle. The flags and `rsp_data` hold until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Issue a command (taken only when idle) |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_kind | input | 2 | Reply kind, encoded as in R4 |
| cmd_in | input | 1 | Sampled command line |
| cmd_out | output | 1 | Bit to drive on the command line |
| cmd_oe | output | 1 | Drive enable for the command line |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | No reply start bit arrived in the window |
| crc_err | output | 1 | Reply CRC mismatch |
| frame_err | output | 1 | Bad direction bit or end bit |
| rsp_data | output | 126 | Reply content |

## Verification
The assertions assume three things about the inputs. `start` is meaningful only when `busy` is low. The line idles high whenever the card is not replying. Each line bit is stable across the clock edge that samples it. The bench changes `cmd_in` and `start` only on falling edges, keeps the line high outside the reply bits it sends, and issues a new command only after `done`. It deliberately pulses `start` during a busy period to exercise the ignore rule.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [1:0] {
    RSP_NONE        = 2'd0,
    RSP_SHORT       = 2'd1,
    RSP_SHORT_NOCRC = 2'd2,
    RSP_LONG        = 2'd3
  } rsp_kind_e;

  // one serial step of the x^7 + x^3 + 1 checksum
  function automatic logic [6:0] crc7_step(input logic [6:0] acc, input logic din);
    logic fb;
    fb = din ^ acc[6];
    return {acc[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

endpackage

// File: rtl/sdc_cmd_tx.sv
module sdc_cmd_tx #(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32,
  parameter int CRC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  output logic             bit_out,
  output logic             active,
  output logic             last
);
  import sdc_pkg::*;

  localparam int HDR_W   = 2 + IDX_W + ARG_W;
  localparam int FRAME_W = HDR_W + CRC_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_W - 1);

  logic [HDR_W-1:0]   hdr;
  logic [CRC_W-1:0]   crc;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;

  assign hdr = {2'b01, idx, arg};

  always_comb begin
    crc = '0;
    for (int i = HDR_W - 1; i >= 0; i--) crc = crc7_step(crc, hdr[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      active <= 1'b0;
    end else if (load) begin
      sh_q   <= {hdr, crc, 1'b1};
      cnt_q  <= '0;
      active <= 1'b1;
    end else if (active) begin
      sh_q  <= {sh_q[FRAME_W-2:0], 1'b1};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_CNT) active <= 1'b0;
    end
  end

  assign bit_out = active ? sh_q[FRAME_W-1] : 1'b1;
  assign last    = active && (cnt_q == LAST_CNT);

endmodule

// File: rtl/sdc_rsp_rx.sv
module sdc_rsp_rx #(
  parameter int IDX_W      = 6,
  parameter int ARG_W      = 32,
  parameter int CRC_W      = 7,
  parameter int LONG_HDR   = 8,
  parameter int LONG_PAY_W = 120,
  parameter int RSP_W      = LONG_HDR - 2 + LONG_PAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             is_long,
  input  logic             line_in,
  output logic             fin,
  output logic             frame_bad,
  output logic             crc_bad,
  output logic [RSP_W-1:0] data
);
  import sdc_pkg::*;

  localparam int SHORT_W  = 2 + IDX_W + ARG_W + CRC_W + 1;
  localparam int SHORT_D  = IDX_W + ARG_W;
  localparam int SHDR_W   = SHORT_W - CRC_W - 1;
  localparam int LONG_W   = LONG_HDR + LONG_PAY_W + CRC_W + 1;
  localparam int FULL_W   = LONG_W - 1;
  localparam int CNT_W    = $clog2(LONG_W);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_W - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_W - 1);

  logic [FULL_W-2:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              act_q;
  logic [FULL_W-1:0] full;
  logic [SHDR_W-1:0] s_hdr;
  logic [CRC_W-1:0]  s_crc, l_crc;

  // frame without its start bit, newest bit at the bottom
  assign full = {sh_q, line_in};
  assign fin  = act_q && (cnt_q == (is_long ? LONG_LAST : SHORT_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (go) begin
      sh_q  <= '0;
      cnt_q <= CNT_W'(1);
      act_q <= 1'b1;
    end else if (act_q) begin
      sh_q  <= full[FULL_W-2:0];
      cnt_q <= cnt_q + 1'b1;
      if (fin) act_q <= 1'b0;
    end
  end

  assign s_hdr = {1'b0, full[SHORT_W-2:CRC_W+1]};

  always_comb begin
    s_crc = '0;
    for (int i = SHDR_W - 1; i >= 0; i--) s_crc = crc7_step(s_crc, s_hdr[i]);
  end

  always_comb begin
    l_crc = '0;
    for (int i = LONG_PAY_W + CRC_W; i >= CRC_W + 1; i--) l_crc = crc7_step(l_crc, full[i]);
  end

  always_comb begin
    if (is_long) begin
      frame_bad = full[FULL_W-1] | ~full[0];
      crc_bad   = (l_crc != full[CRC_W:1]);
      data      = full[FULL_W-2:CRC_W+1];
    end else begin
      frame_bad = full[SHORT_W-2] | ~full[0];
      crc_bad   = (s_crc != full[CRC_W:1]);
      data      = '0;
      data[SHORT_D-1:0] = full[SHORT_W-3:CRC_W+1];
    end
  end

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int IDX_W      = 6,
  parameter int ARG_W      = 32,
  parameter int CRC_W      = 7,
  parameter int LONG_HDR   = 8,
  parameter int LONG_PAY_W = 120,
  parameter int TIMEOUT    = 64,
  parameter int RSP_W      = LONG_HDR - 2 + LONG_PAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic [1:0]       rsp_kind,
  input  logic             cmd_in,
  output logic             cmd_out,
  output logic             cmd_oe,
  output logic             busy,
  output logic             done,
  output logic             timeout,
  output logic             crc_err,
  output logic             frame_err,
  output logic [RSP_W-1:0] rsp_data
);
  import sdc_pkg::*;

  localparam int WCNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [WCNT_W-1:0] WAIT_LAST = WCNT_W'(TIMEOUT - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_LISTEN, ST_RECV} state_e;

  state_e            st_q;
  rsp_kind_e         kind_q;
  logic [WCNT_W-1:0] wait_q;
  logic              accept, tx_active, tx_last, rx_go, rx_fin, rx_fbad, rx_cbad;
  logic [RSP_W-1:0]  rx_data;

  assign accept = (st_q == ST_IDLE) && start;
  assign rx_go  = (st_q == ST_LISTEN) && !cmd_in;

  sdc_cmd_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W), .CRC_W(CRC_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept), .idx(cmd_index), .arg(cmd_arg),
    .bit_out(cmd_out), .active(tx_active), .last(tx_last)
  );

  sdc_rsp_rx #(.IDX_W(IDX_W), .ARG_W(ARG_W), .CRC_W(CRC_W), .LONG_HDR(LONG_HDR),
               .LONG_PAY_W(LONG_PAY_W), .RSP_W(RSP_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .go(rx_go), .is_long(kind_q == RSP_LONG),
    .line_in(cmd_in), .fin(rx_fin), .frame_bad(rx_fbad), .crc_bad(rx_cbad), .data(rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      kind_q    <= RSP_NONE;
      wait_q    <= '0;
      done      <= 1'b0;
      timeout   <= 1'b0;
      crc_err   <= 1'b0;
      frame_err <= 1'b0;
      rsp_data  <= '0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          kind_q    <= rsp_kind_e'(rsp_kind);
          timeout   <= 1'b0;
          crc_err   <= 1'b0;
          frame_err <= 1'b0;
          rsp_data  <= '0;
          st_q      <= ST_SEND;
        end
        ST_SEND: if (tx_last) begin
          wait_q <= '0;
          if (kind_q == RSP_NONE) begin
            st_q <= ST_IDLE;
            done <= 1'b1;
          end else begin
            st_q <= ST_LISTEN;
          end
        end
        ST_LISTEN: begin
          if (!cmd_in) begin
            st_q <= ST_RECV;
          end else if (wait_q == WAIT_LAST) begin
            st_q    <= ST_IDLE;
            done    <= 1'b1;
            timeout <= 1'b1;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        ST_RECV: if (rx_fin) begin
          st_q      <= ST_IDLE;
          done      <= 1'b1;
          frame_err <= rx_fbad;
          crc_err   <= rx_cbad && (kind_q != RSP_SHORT_NOCRC);
          rsp_data  <= rx_data;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign cmd_oe = tx_active;

endmodule

// File: rtl/sdc_cmd_checker.sv
module sdc_cmd_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic cmd_oe,
  input logic timeout,
  input logic crc_err,
  input logic frame_err
);

  AST_OE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy); // R2

  AST_OE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> $past(start && !busy)); // R2

  AST_NONE_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4

  AST_BUSY_EXITS_VIA_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done)); // R5

  AST_TIMEOUT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timeout) |-> (!crc_err && !frame_err)); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(timeout) && $stable(crc_err) && $stable(frame_err))); // R11

endmodule

bind sd_cmd_engine sdc_cmd_checker u_sdc_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cmd_oe(cmd_oe), .timeout(timeout), .crc_err(crc_err), .frame_err(frame_err)
);

// File: tb/sd_cmd_engine_test.sv
`timescale 1ns/1ps
module sd_cmd_engine_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [5:0]   cmd_index = '0;
  logic [31:0]  cmd_arg = '0;
  logic [1:0]   rsp_kind = '0;
  logic         cmd_in = 1'b1;
  logic         cmd_out, cmd_oe, busy, done, timeout, crc_err, frame_err;
  logic [125:0] rsp_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  sd_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .rsp_kind(rsp_kind), .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .busy(busy), .done(done), .timeout(timeout), .crc_err(crc_err),
    .frame_err(frame_err), .rsp_data(rsp_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [135:0] act, input logic [135:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [119:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic m = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (m) c = c ^ 7'b0001001;
    end
    return c;
  endfunction

  // issue a command and compare the 48 transmitted bits (R2, R3)
  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] kind,
                       output logic [6:0] seen_crc);
    logic [47:0] exp_f, got;
    logic        oe_ok = 1'b1;
    exp_f = {2'b01, idx, arg, ref_crc({80'b0, 2'b01, idx, arg}, 40), 1'b1};
    @(negedge clk);
    cmd_index = idx; cmd_arg = arg; rsp_kind = kind; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check("R11 flags cleared on accept", {timeout, crc_err, frame_err, rsp_data}, '0);
    for (int k = 47; k >= 0; k--) begin
      @(negedge clk);
      got[k] = cmd_out;
      if (!cmd_oe) oe_ok = 1'b0;
    end
    check("R2 oe high for whole frame", oe_ok, 1'b1);
    check("R2 transmitted frame", got, exp_f);
    seen_crc = got[7:1];
  endtask

  // drive a reply after gap idle bits, then sample just after the last sampling edge
  task automatic reply(input logic [135:0] f, input int len, input int gap);
    for (int g = 0; g < gap; g++) begin @(negedge clk); cmd_in = 1'b1; end
    for (int j = len - 1; j >= 0; j--) begin @(negedge clk); cmd_in = f[j]; end
    @(posedge clk); #1;
  endtask

  function automatic logic [47:0] short_frame(input logic [37:0] body, input logic dir,
                                              input logic endb, input logic crc_flip);
    logic [6:0] c = ref_crc({82'b0, 1'b0, dir, body}, 40) ^ {6'b0, crc_flip};
    return {1'b0, dir, body, c, endb};
  endfunction

  function automatic logic [135:0] long_frame(input logic [5:0] rsv, input logic [119:0] pay,
                                              input logic crc_flip);
    logic [6:0] c = ref_crc(pay, 120) ^ {6'b0, crc_flip};
    return {1'b0, 1'b0, rsv, pay, c, 1'b1};
  endfunction

  task automatic t_reset;
    #1;
    check("R1 reset outputs", {busy, done, cmd_oe, timeout, crc_err, frame_err, cmd_out},
          {6'b0, 1'b1});
    check("R1 reset data", rsp_data, '0);
  endtask

  task automatic t_no_reply;
    logic [6:0] c;
    issue(6'd0, 32'h0, 2'd0, c);
    check("R3 crc of index 0 arg 0", c, 7'h4A);
    @(posedge clk); #1;
    check("R4 done after last bit", {done, busy, timeout, crc_err, frame_err}, 5'b10000);
    @(posedge clk); #1;
    check("R11 done one cycle", done, 1'b0);
  endtask

  task automatic t_short_ok;
    logic [6:0] c;
    issue(6'd8, 32'h1AA, 2'd1, c);
    check("R3 crc of index 8 arg 1AA", c, 7'h43);
    // a start while busy must not launch anything (R5)
    @(negedge clk); start = 1'b1; cmd_index = 6'd55;
    @(negedge clk); start = 1'b0;
    reply({88'b0, short_frame({6'd8, 32'h1AA}, 1'b0, 1'b1, 1'b0)}, 48, 0);
    check("R7 short done clean", {done, timeout, crc_err, frame_err}, 4'b1000);
    check("R7 short data", rsp_data, {88'b0, 6'd8, 32'h1AA});
    @(negedge clk); @(negedge clk);
    check("R5 no frame after busy start", {busy, cmd_oe}, 2'b00);
  endtask

  task automatic t_short_nocrc;
    logic [6:0] c;
    logic [47:0] f;
    issue(6'd41, 32'h00FF8000, 2'd2, c);
    f = {1'b0, 1'b0, 6'h3F, 32'h80FF8000, 7'h7F, 1'b1};
    reply({88'b0, f}, 48, 3);
    check("R9 kind 2 ignores crc", {done, crc_err, frame_err}, 3'b100);
    check("R7 kind 2 data", rsp_data, {88'b0, 6'h3F, 32'h80FF8000});
  endtask

  task automatic t_short_badcrc;
    logic [6:0] c;
    issue(6'd13, 32'h12340000, 2'd1, c);
    reply({88'b0, short_frame({6'd13, 32'h00000900}, 1'b0, 1'b1, 1'b1)}, 48, 1);
    check("R9 short crc error", {done, crc_err, frame_err}, 3'b110);
    repeat (5) @(posedge clk); #1;
    check("R11 crc flag held", crc_err, 1'b1);
  endtask

  task automatic t_frame_errs;
    logic [6:0] c;
    issue(6'd3, 32'h0, 2'd1, c);
    reply({88'b0, short_frame({6'd3, 32'hABCD0000}, 1'b1, 1'b1, 1'b0)}, 48, 0);
    check("R10 direction bit set", {done, frame_err, crc_err}, 3'b110);
    issue(6'd3, 32'h0, 2'd1, c);
    reply({88'b0, short_frame({6'd3, 32'hABCD0000}, 1'b0, 1'b0, 1'b0)}, 48, 2);
    check("R10 end bit missing", {done, frame_err, crc_err}, 3'b110);
  endtask

  task automatic t_long;
    logic [6:0] c;
    logic [119:0] pay = 120'h1D_4142_4344_4546_4748_4950_5152_53C0;
    issue(6'd2, 32'h0, 2'd3, c);
    reply(long_frame(6'h3F, pay, 1'b0), 136, 4);
    check("R8 long clean", {done, crc_err, frame_err, timeout}, 4'b1000);
    check("R8 long data", rsp_data, {10'b0, 6'h3F, pay});
    issue(6'd9, 32'h00010000, 2'd3, c);
    reply(long_frame(6'h3F, ~pay, 1'b1), 136, 0);
    check("R9 long crc error", {done, crc_err, frame_err}, 3'b110);
  endtask

  task automatic t_timeout;
    logic [6:0] c;
    issue(6'd55, 32'h0, 2'd1, c);
    repeat (64) @(posedge clk); #1;
    check("R6 not yet timed out", {done, busy}, 2'b01);
    @(posedge clk); #1;
    check("R6 timeout at window end", {done, timeout, busy}, 3'b110);
    // start bit on the final sampling edge is still taken
    issue(6'd7, 32'h00020000, 2'd1, c);
    reply({88'b0, short_frame({6'd7, 32'h00000700}, 1'b0, 1'b1, 1'b0)}, 48, 63);
    check("R6 late start accepted", {done, timeout, crc_err, frame_err}, 4'b1000);
    check("R6 late reply data", rsp_data, {88'b0, 6'd7, 32'h00000700});
  endtask

  initial begin
    t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_no_reply;
    t_short_ok;
    t_short_nocrc;
    t_short_badcrc;
    t_frame_errs;
    t_long;
    t_timeout;
    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule